// File: doc/BRIEF.md
# Receive Timeslot PRBS Checker with Milliwatt Insertion

This block sits on the receive byte path of a 24-channel T1 frame. Each received byte arrives with a strobe and the index of its timeslot. A 24-bit enable word selects the timeslots under test, and any combination of timeslots may be selected. The selected bytes are joined in their arrival order into one continuous bit stream. That stream goes to a self-synchronizing checker for the 2^15-1 pseudo-random sequence. Each mismatching bit adds one to an 8-bit error counter. When the counter rolls over, a sticky overflow status bit is set. That status bit, gated by an interrupt enable, drives the interrupt output.

When the mode input is high, the checker is idle. The block then writes the mu-law digital milliwatt pattern onto the selected timeslots of the outgoing byte stream, with the sign bit in the MSB. All other timeslots pass through unchanged. When the mode input is low, the outgoing stream is an exact copy of the incoming stream, delayed by one register stage. The checker locks by itself once enough received bits have passed through it, so the error count from the first bytes after a start is not meaningful.

Top module: `ts_prbs_rx_top`

## Requirements
- R1: A byte feeds the checker only when `in_valid` is high, `in_slot` is in the range 0 to 23, bit `in_slot` of `rx_test_en` is set, and `mw_mode` is low. Any combination of enable bits is allowed. Slot indices 24 to 31 are never selected.
- R2: The bits of each checked byte are compared MSB first. The expected bit is the XOR of the 15th-last and 14th-last bits received in the joined stream of checked bytes. Each received bit is then shifted into the 15-bit history. The history is all zeros after reset.
- R3: In the cycle after a checked byte, `err_count` has grown by the number of mismatching bits in that byte, from 0 to 8, modulo 256. It does not change in any other cycle, apart from a clear (R7).
- R4: A joined stream that is an error-free 2^15-1 sequence (x^15 + x^14 + 1) gives no new errors once the first 15 bits have passed.
- R5: An addition that carries out of the 8-bit counter sets `ovf_status` in the same cycle that the counter updates. The bit then stays set until a `sts_clr` pulse clears it. If an overflow and a clear fall in the same cycle, the overflow wins.
- R6: `irq` is high exactly when both `ovf_status` and `irq_en` are high.
- R7: A `cnt_clr` pulse sets `err_count` to 0 in the next cycle. Any errors found in the same cycle are discarded and cannot cause an overflow.
- R8: With `mw_mode` low, `out_valid` follows `in_valid` one cycle later. On each valid byte, `out_slot` and `out_byte` take `in_slot` and `in_byte` one cycle later. They hold their values while `in_valid` is low.
- R9: With `mw_mode` high, a valid byte on a selected timeslot leaves as entry P of the pattern 1E, 0B, 0B, 1E, 9E, 8B, 8B, 9E (hex, entries 0 to 7). P is a 3-bit frame phase. It is 0 after reset and steps by one after each valid byte with slot 23, in either mode. Unselected timeslots pass through unchanged, and `err_count` does not move.
- R10: If exactly one bit of an otherwise correct, locked sequence is flipped, the counter grows by exactly 3 in total: once for the flipped bit and once for each of its two feedback taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe for an incoming byte |
| in_slot | input | 5 | Timeslot index of the incoming byte |
| in_byte | input | 8 | Incoming byte |
| rx_test_en | input | 24 | Per-timeslot test enable |
| mw_mode | input | 1 | 1 = milliwatt insertion, 0 = PRBS check |
| cnt_clr | input | 1 | Pulse that zeros the error counter |
| sts_clr | input | 1 | Pulse that clears the overflow status |
| irq_en | input | 1 | Lets the overflow status reach the interrupt |
| out_valid | output | 1 | Strobe for an outgoing byte |
| out_slot | output | 5 | Timeslot index of the outgoing byte |
| out_byte | output | 8 | Outgoing byte |
| err_count | output | 8 | Bit error counter |
| ovf_status | output | 1 | Sticky counter-overflow status |
| irq | output | 1 | Interrupt |

## Verification
The embedded properties check on every cycle that the counter holds when nothing is added, that a clear empties it, that the overflow status is sticky, that the interrupt never appears without the status, that data passes through unchanged in PRBS mode, and that the counter is frozen in milliwatt mode. Some behaviours can only be shown by the bench's scenarios. These are the exact bit-level mismatch count across an arbitrary set of timeslots, lock on a clean sequence, the three-error signature of a single flipped bit, the frame-phase ordering of the milliwatt bytes, and the cycle in which a wrap sets the status bit.

// File: rtl/ts_prbs_pkg.sv
package ts_prbs_pkg;
  localparam int NSLOT   = 24;
  localparam int SLOT_W  = 5;
  localparam int BYTE_W  = 8;
  localparam int PRBS_N  = 15;
  localparam int CNT_W   = 8;
  localparam int MW_LEN  = 8;
  localparam int PH_W    = $clog2(MW_LEN);

  // mu-law digital milliwatt, one entry per frame, sign bit in the MSB
  function automatic logic [BYTE_W-1:0] mw_byte(input logic [PH_W-1:0] ph);
    logic [BYTE_W-1:0] mag;
    // the second half of the cycle mirrors the first with the sign bit set
    case (ph[1:0])
      2'd0:    mag = 8'h1E;
      2'd1:    mag = 8'h0B;
      2'd2:    mag = 8'h0B;
      default: mag = 8'h1E;
    endcase
    return ph[2] ? (mag | 8'h80) : mag;
  endfunction
endpackage

// File: rtl/prbs_selfsync_chk.sv
module prbs_selfsync_chk #(
  parameter int BYTE_W = 8,
  parameter int PRBS_N = 15,
  parameter int TAP_HI = 15,
  parameter int TAP_LO = 14,
  localparam int ERR_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [ERR_W-1:0]  err_bits
);
  logic [PRBS_N-1:0] hist_q, hist_d;
  logic [BYTE_W-1:0] mism;

  always_comb begin
    logic [PRBS_N-1:0] h;
    h = hist_q;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      mism[i] = byte_in[i] ^ h[TAP_HI-1] ^ h[TAP_LO-1];
      h = {h[PRBS_N-2:0], byte_in[i]};
    end
    hist_d = h;
  end

  always_comb begin
    err_bits = '0;
    if (byte_vld) begin
      for (int i = 0; i < BYTE_W; i++) err_bits = err_bits + ERR_W'(mism[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (byte_vld) hist_q <= hist_d;
  end

  // R2: no errors can be reported when no byte is checked
  p_idle_noerr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |-> err_bits == '0);
endmodule

// File: rtl/err_acc.sv
module err_acc #(
  parameter int CNT_W = 8,
  parameter int ADD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADD_W-1:0] add_val,
  input  logic             cnt_clr,
  input  logic             sts_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_sts
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             sts_d;
  logic             cnt_en;

  always_comb begin
    sum    = {1'b0, count} + (CNT_W+1)'(add_val);
    cnt_en = cnt_clr || (add_val != '0);
    cnt_d  = cnt_clr ? '0 : sum[CNT_W-1:0];
    if (!cnt_clr && sum[CNT_W]) sts_d = 1'b1;
    else if (sts_clr)           sts_d = 1'b0;
    else                        sts_d = ovf_sts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_sts <= 1'b0;
    else        ovf_sts <= sts_d;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (add_val == '0 && !cnt_clr) |=> $stable(count));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sts && !sts_clr) |=> ovf_sts);
endmodule

// File: rtl/mw_insert.sv
module mw_insert
  import ts_prbs_pkg::*;
#(
  parameter int LAST_SLOT = NSLOT - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              repl,
  output logic              out_vld,
  output logic [SLOT_W-1:0] out_slot,
  output logic [BYTE_W-1:0] out_byte
);
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [BYTE_W-1:0] byte_d;
  logic              frame_end;

  always_comb begin
    frame_end = in_vld && (in_slot == SLOT_W'(LAST_SLOT));
    ph_d      = ph_q + PH_W'(1);
    byte_d    = repl ? mw_byte(ph_q) : in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ph_q <= '0;
    else if (frame_end) ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_slot <= '0;
      out_byte <= '0;
    end else if (in_vld) begin
      out_slot <= in_slot;
      out_byte <= byte_d;
    end
  end

  p_slot_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (out_slot == $past(in_slot)));
endmodule

// File: rtl/ts_prbs_rx_top.sv
module ts_prbs_rx_top
  import ts_prbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [NSLOT-1:0]  rx_test_en,
  input  logic              mw_mode,
  input  logic              cnt_clr,
  input  logic              sts_clr,
  input  logic              irq_en,
  output logic              out_valid,
  output logic [SLOT_W-1:0] out_slot,
  output logic [BYTE_W-1:0] out_byte,
  output logic [CNT_W-1:0]  err_count,
  output logic              ovf_status,
  output logic              irq
);
  localparam int SLOT_SPAN = 2 ** SLOT_W;
  localparam int ERR_W     = $clog2(BYTE_W + 1);

  logic [SLOT_SPAN-1:0] en_pad;
  logic                 slot_sel, chk_vld, repl;
  logic [ERR_W-1:0]     err_bits;

  always_comb begin
    en_pad   = {{(SLOT_SPAN-NSLOT){1'b0}}, rx_test_en};
    slot_sel = in_valid && en_pad[in_slot];
    chk_vld  = slot_sel && !mw_mode;
    repl     = slot_sel && mw_mode;
    irq      = ovf_status && irq_en;
  end

  prbs_selfsync_chk #(.BYTE_W(BYTE_W), .PRBS_N(PRBS_N), .TAP_HI(15), .TAP_LO(14)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(chk_vld), .byte_in(in_byte), .err_bits(err_bits));

  err_acc #(.CNT_W(CNT_W), .ADD_W(ERR_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .add_val(err_bits), .cnt_clr(cnt_clr), .sts_clr(sts_clr),
    .count(err_count), .ovf_sts(ovf_status));

  mw_insert u_mw (
    .clk(clk), .rst_n(rst_n), .in_vld(in_valid), .in_slot(in_slot), .in_byte(in_byte),
    .repl(repl), .out_vld(out_valid), .out_slot(out_slot), .out_byte(out_byte));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mw_mode) |=> (out_byte == $past(in_byte)));
  p_mw_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_mode && !cnt_clr) |=> $stable(err_count));
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_status && irq_en));
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));
endmodule

// File: tb/ts_prbs_rx_top_test.sv
module ts_prbs_rx_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] in_slot = '0;
  logic [7:0] in_byte = '0;
  logic [23:0] rx_test_en = '0;
  logic mw_mode = 1'b0, cnt_clr = 1'b0, sts_clr = 1'b0, irq_en = 1'b0;
  logic out_valid, ovf_status, irq;
  logic [4:0] out_slot;
  logic [7:0] out_byte, err_count;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // bench model state
  logic [14:0] m_hist = '0;
  logic [14:0] gen = 15'h1ACE;
  int m_cnt = 0;
  bit m_sts = 0, m_vld = 0;
  logic [4:0] m_slot = '0;
  logic [7:0] m_byte = '0;
  int m_ph = 0;

  always #10 clk = ~clk;

  ts_prbs_rx_top uut (.*);

  function automatic logic [7:0] mw_ref(input int p);
    logic [7:0] t [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
    return t[p % 8];
  endfunction

  function automatic int chk_ref(inout logic [14:0] h, input logic [7:0] b);
    int n = 0;
    for (int i = 7; i >= 0; i--) begin
      if ((h[14] ^ h[13]) != b[i]) n++;
      h = {h[13:0], b[i]};
    end
    return n;
  endfunction

  function automatic logic [7:0] gen_byte(inout logic [14:0] g);
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      r[i] = g[14] ^ g[13];
      g = {g[13:0], r[i]};
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input bit v, input logic [4:0] s, input logic [7:0] b,
                      input bit cc, input bit sc);
    bit sel;
    int n, sum;
    in_valid = v; in_slot = s; in_byte = b; cnt_clr = cc; sts_clr = sc;
    sel = v && (s < 24) && rx_test_en[s];           // R1
    n = 0;
    if (sel && !mw_mode) n = chk_ref(m_hist, b);     // R2
    m_vld = v;
    if (v) begin
      m_slot = s;
      m_byte = (sel && mw_mode) ? mw_ref(m_ph) : b;  // R8, R9
      if (s == 5'd23) m_ph++;
    end
    if (cc) m_cnt = 0;                               // R7
    else begin
      sum = m_cnt + n;
      if (sum > 255) m_sts = 1;                      // R5
      else if (sc) m_sts = 0;
      m_cnt = sum % 256;                             // R3
    end
    if (cc && sc) m_sts = 0;
    @(negedge clk);
    cnt_clr = 0; sts_clr = 0;
    check(out_valid == m_vld, "R8 out_valid", out_valid, m_vld);
    check(out_slot == m_slot, "R8 out_slot", out_slot, m_slot);
    check(out_byte == m_byte, mw_mode ? "R9 out_byte" : "R8 out_byte", out_byte, m_byte);
    check(err_count == 8'(m_cnt), "R3 err_count", err_count, m_cnt);
    check(ovf_status == m_sts, "R5 ovf_status", ovf_status, m_sts);
    check(irq == (m_sts && irq_en), "R6 irq", irq, m_sts && irq_en);
  endtask

  // kind 0: random bytes, 1: clean sequence on enabled slots; flip_slot gets bit flip_bit inverted
  task automatic frame(input int kind, input int flip_slot, input int flip_bit);
    logic [7:0] b;
    for (int s = 0; s < 24; s++) begin
      if (kind == 1 && rx_test_en[s]) b = gen_byte(gen);
      else b = 8'($urandom);
      if (s == flip_slot) b[flip_bit] = ~b[flip_bit];
      if ($urandom_range(0, 7) == 0) step(0, 5'($urandom), 8'($urandom), 0, 0);
      step(1, 5'(s), b, 0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(err_count == 0 && !ovf_status && !irq && !out_valid, "R3 reset", err_count, 0);

    // R2/R3: random data over random slot sets
    for (int k = 0; k < 6; k++) begin
      rx_test_en = 24'($urandom);
      frame(0, -1, 0);
    end

    // R4: clean sequence on a scattered slot set locks and stays error free
    rx_test_en = 24'h813204;
    step(1, 5'd0, 8'h00, 1, 1);
    frame(1, -1, 0); frame(1, -1, 0);
    base = err_count;
    for (int k = 0; k < 10; k++) frame(1, -1, 0);
    check(err_count == 8'(base), "R4 locked no errors", err_count, base);

    // R10: one flipped bit gives exactly three errors
    rx_test_en = 24'h000100;
    frame(1, -1, 0); frame(1, -1, 0); frame(1, -1, 0);
    base = err_count;
    frame(1, 8, 3);
    for (int k = 0; k < 4; k++) frame(1, -1, 0);
    check(err_count == 8'(base + 3), "R10 single flip", err_count, base + 3);

    // R1: slots 24..31 are never selected even with all enables set
    rx_test_en = 24'hFFFFFF;
    base = err_count;
    for (int k = 24; k < 32; k++) step(1, 5'(k), 8'($urandom), 0, 0);
    check(err_count == 8'(base), "R1 out-of-range slot", err_count, base);

    // R5/R6: drive to overflow with the interrupt gated off, then on
    irq_en = 0;
    while (!ovf_status) frame(0, -1, 0);
    check(irq == 0, "R6 irq masked", irq, 0);
    irq_en = 1;
    step(0, 0, 0, 0, 0);
    check(irq == 1, "R6 irq enabled", irq, 1);
    frame(0, -1, 0);
    check(ovf_status == 1, "R5 sticky", ovf_status, 1);
    step(0, 0, 0, 0, 1);
    check(ovf_status == 0, "R5 cleared", ovf_status, 0);

    // R7: clear with a checked byte in the same cycle
    step(1, 5'd3, 8'hA5, 1, 0);
    check(err_count == 0, "R7 clear wins", err_count, 0);

    // R9: milliwatt insertion with a random mask, counter frozen
    mw_mode = 1;
    base = err_count;
    for (int k = 0; k < 12; k++) begin
      rx_test_en = 24'($urandom);
      frame(0, -1, 0);
    end
    check(err_count == 8'(base), "R9 counter frozen", err_count, base);
    mw_mode = 0;

    // mixed random with clear pulses
    for (int k = 0; k < 400; k++) begin
      rx_test_en = ($urandom_range(0, 3) == 0) ? 24'($urandom) : rx_test_en;
      mw_mode = ($urandom_range(0, 9) == 0);
      irq_en = 1'($urandom);
      step(1'($urandom_range(0, 5) != 0), 5'($urandom), 8'($urandom),
           $urandom_range(0, 40) == 0, $urandom_range(0, 20) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule